// File: doc/BRIEF.md
# Baud Accumulator Word Calculator

This block derives the two programming words for a fractional-accumulator tick generator. That generator adds an increment word on each clock and subtracts a limit word when its count reaches or passes the limit. Each subtraction produces a one-clock tick, so ticks are narrow pulses and not a square wave. The tick rate is set to sixteen times the serial baud rate, which lets a receiver sample near the middle of each bit.

Given the system clock frequency and the baud rate, the calculator forms the tick rate as the baud rate times 16. It reduces the clock and tick rates by their greatest common divisor, found with Euclid's remainder loop. The reduced tick rate becomes the increment word, and the reduced clock rate minus the increment becomes the limit word. All remainders and quotients come from one shared restoring divider that produces one quotient bit per clock.

Software or a boot sequencer starts the block with a pulse and waits for a one-cycle completion pulse. An overflow flag reports results that do not fit the output words and inputs that cannot be used.

Top module: `baud_word_calc`

## Requirements
- R1: After reset, busy, done and overflow are 0, and both output words are 0.
- R2: On a successful run, the increment word equals 16*baud / G, where G = gcd(clock, 16*baud).
- R3: On a successful run, the limit word equals clock/G minus the increment word.
- R4: A clock of 50,000,000 with a baud rate of 9600 yields an increment of 0x30 and a limit of 0x3CD9.
- R5: If the increment would exceed 4095, or the limit would exceed 65535, the run ends with overflow = 1 and both words = 0. The values 4095 and 65535 themselves are accepted.
- R6: A clock of 0, a baud rate of 0, or a tick rate greater than the clock ends the run with overflow = 1 and both words = 0. A tick rate equal to the clock is valid.
- R7: A start pulse seen while idle raises busy on the next cycle. Busy stays high until done, which lasts exactly one cycle and is only high while busy. Busy is low on the cycle after done.
- R8: A start pulse, or a change of input values, while busy has no effect on the run in progress. The result reflects the inputs present when the run was accepted.
- R9: Overflow and both output words change only on the cycle in which done is high. During a run they keep the previous result.
- R10: After done, the outputs hold their values while idle until the next run completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Pulse that begins a calculation while idle |
| clkFreq | input | 32 | System clock frequency in Hz |
| baudRate | input | 20 | Serial baud rate |
| busy | output | 1 | High from accepted start through done |
| done | output | 1 | One-cycle completion pulse |
| overflow | output | 1 | Result unusable; both words forced to zero |
| incWord | output | 12 | Accumulator increment word |
| limitWord | output | 16 | Accumulator limit word |

## Verification
The bench sweeps a grid of clock and baud values and compares each result against a GCD computed arithmetically. A broken divider or a wrong remainder hand-off in the Euclid loop would show up there as wrong words. It also exercises both sides of each limit. An increment of exactly 4095 against 4096, and a limit of exactly 65535 against 65536, would catch a comparison that is off by one. A tick rate equal to the clock, against one slightly above it, would catch a validity check that rejects or accepts the wrong side. A start pulse with new inputs in the middle of a run would reveal a design that restarts, or that reads its inputs live instead of capturing them. The bench also watches the outputs during the following run, which would catch a design that publishes intermediate values before done.

// File: rtl/baudcalc_pkg.sv
package baudcalc_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_GCD_LOOP,
    ST_DIV_FREQ,
    ST_DIV_LIMIT,
    ST_DONE
  } calcState_t;

  // which operand pair feeds the shared divider
  typedef enum logic [1:0] {
    OPS_GCD,
    OPS_FREQ,
    OPS_LIMIT
  } opSel_t;

  typedef struct packed {
    logic   captureIn; // latch clock and tick rate, seed Euclid registers
    logic   divGo;     // launch the divider on the selected operands
    opSel_t opSel;
    logic   gcdStep;   // a <= b, b <= a mod b
    logic   saveInc;   // keep reduced tick rate
    logic   commit;    // publish results (or zeros on overflow)
    logic   rejectIn;  // commit because the inputs were unusable
  } ctrlStrobe_t;

endpackage

// File: rtl/baudcalc_divider.sv
module baudcalc_divider #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         go,
  input  logic [W-1:0] dividend,
  input  logic [W-1:0] divisor,
  output logic [W-1:0] quotient,
  output logic [W-1:0] remainder,
  output logic         fin
);
  localparam int CW = $clog2(W + 1);

  logic [W-1:0]  remR, quoR, dvsR;
  logic [CW-1:0] stepCnt;
  logic          running;
  logic [W:0]    shifted, diff;

  always_comb begin
    shifted = {remR, quoR[W-1]};
    diff    = shifted - {1'b0, dvsR};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      remR    <= '0;
      quoR    <= '0;
      dvsR    <= '0;
      stepCnt <= '0;
      running <= 1'b0;
      fin     <= 1'b0;
    end else begin
      fin <= 1'b0;
      if (go) begin
        remR    <= '0;
        quoR    <= dividend;
        dvsR    <= divisor;
        stepCnt <= CW'(W);
        running <= 1'b1;
      end else if (running) begin
        if (!diff[W]) begin
          remR <= diff[W-1:0];
          quoR <= {quoR[W-2:0], 1'b1};
        end else begin
          remR <= shifted[W-1:0];
          quoR <= {quoR[W-2:0], 1'b0};
        end
        stepCnt <= stepCnt - 1'b1;
        if (stepCnt == CW'(1)) begin
          running <= 1'b0;
          fin     <= 1'b1;
        end
      end
    end
  end

  assign quotient  = quoR;
  assign remainder = remR;
endmodule

// File: rtl/baudcalc_ctrl.sv
module baudcalc_ctrl
  import baudcalc_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic        inputsBad,
  input  logic        bZero,
  input  logic        divDone,
  output ctrlStrobe_t strb,
  output logic        busy,
  output logic        done
);
  calcState_t state, nextState;
  logic       launched;

  always_comb begin
    strb      = '0;
    nextState = state;
    unique case (state)
      ST_IDLE: begin
        if (start) begin
          if (inputsBad) begin
            strb.commit   = 1'b1;
            strb.rejectIn = 1'b1;
            nextState     = ST_DONE;
          end else begin
            strb.captureIn = 1'b1;
            nextState      = ST_GCD_LOOP;
          end
        end
      end
      ST_GCD_LOOP: begin
        strb.opSel = OPS_GCD;
        if (!launched) begin
          if (bZero) nextState = ST_DIV_FREQ;
          else       strb.divGo = 1'b1;
        end else if (divDone) begin
          strb.gcdStep = 1'b1;
        end
      end
      ST_DIV_FREQ: begin
        strb.opSel = OPS_FREQ;
        if (!launched) begin
          strb.divGo = 1'b1;
        end else if (divDone) begin
          strb.saveInc = 1'b1;
          nextState    = ST_DIV_LIMIT;
        end
      end
      ST_DIV_LIMIT: begin
        strb.opSel = OPS_LIMIT;
        if (!launched) begin
          strb.divGo = 1'b1;
        end else if (divDone) begin
          strb.commit = 1'b1;
          nextState   = ST_DONE;
        end
      end
      ST_DONE: nextState = ST_IDLE;
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      launched <= 1'b0;
    end else begin
      state <= nextState;
      if (strb.divGo)   launched <= 1'b1;
      else if (divDone) launched <= 1'b0;
    end
  end

  assign busy = (state != ST_IDLE);
  assign done = (state == ST_DONE);
endmodule

// File: rtl/baudcalc_dpath.sv
module baudcalc_dpath
  import baudcalc_pkg::*;
#(
  parameter int CLK_W    = 32,
  parameter int BAUD_W   = 20,
  parameter int INC_W    = 12,
  parameter int LIM_W    = 16,
  parameter int OVS_LOG2 = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strb,
  input  logic [CLK_W-1:0]  clkFreq,
  input  logic [BAUD_W-1:0] baudRate,
  output logic              inputsBad,
  output logic              bZero,
  output logic              divDone,
  output logic [INC_W-1:0]  incWord,
  output logic [LIM_W-1:0]  limitWord,
  output logic              overflow
);
  localparam int TICK_W = BAUD_W + OVS_LOG2;
  localparam int DW     = (CLK_W > TICK_W) ? CLK_W : TICK_W;

  logic [DW-1:0] clkExt, tickExt;
  logic [DW-1:0] clkHold, tickHold, aReg, bReg, incReg;
  logic [DW-1:0] opDividend, opDivisor, divQuo, divRem, limFull;
  logic          incOver, limOver;

  always_comb begin
    clkExt    = DW'(clkFreq);
    tickExt   = DW'(baudRate) << OVS_LOG2;
    inputsBad = (clkFreq == '0) || (baudRate == '0) || (tickExt > clkExt);
    bZero     = (bReg == '0);
  end

  always_comb begin
    unique case (strb.opSel)
      OPS_FREQ:  begin opDividend = tickHold; opDivisor = aReg; end
      OPS_LIMIT: begin opDividend = clkHold;  opDivisor = aReg; end
      default:   begin opDividend = aReg;     opDivisor = bReg; end
    endcase
  end

  baudcalc_divider #(.W(DW)) u_div (
    .clk      (clk),
    .rstN     (rstN),
    .go       (strb.divGo),
    .dividend (opDividend),
    .divisor  (opDivisor),
    .quotient (divQuo),
    .remainder(divRem),
    .fin      (divDone)
  );

  always_comb begin
    limFull = divQuo - incReg;
    incOver = |incReg[DW-1:INC_W];
    limOver = |limFull[DW-1:LIM_W];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      clkHold  <= '0;
      tickHold <= '0;
      aReg     <= '0;
      bReg     <= '0;
      incReg   <= '0;
    end else begin
      if (strb.captureIn) begin
        clkHold  <= clkExt;
        tickHold <= tickExt;
        aReg     <= clkExt;
        bReg     <= tickExt;
      end else if (strb.gcdStep) begin
        aReg <= bReg;
        bReg <= divRem;
      end
      if (strb.saveInc) incReg <= divQuo;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      incWord   <= '0;
      limitWord <= '0;
      overflow  <= 1'b0;
    end else if (strb.commit) begin
      if (strb.rejectIn || incOver || limOver) begin
        incWord   <= '0;
        limitWord <= '0;
        overflow  <= 1'b1;
      end else begin
        incWord   <= incReg[INC_W-1:0];
        limitWord <= limFull[LIM_W-1:0];
        overflow  <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/baud_word_calc.sv
module baud_word_calc
  import baudcalc_pkg::*;
#(
  parameter int CLK_W    = 32,
  parameter int BAUD_W   = 20,
  parameter int INC_W    = 12,
  parameter int LIM_W    = 16,
  parameter int OVS_LOG2 = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [CLK_W-1:0]  clkFreq,
  input  logic [BAUD_W-1:0] baudRate,
  output logic              busy,
  output logic              done,
  output logic              overflow,
  output logic [INC_W-1:0]  incWord,
  output logic [LIM_W-1:0]  limitWord
);
  ctrlStrobe_t strb;
  logic        inputsBad, bZero, divDone;

  baudcalc_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .start    (start),
    .inputsBad(inputsBad),
    .bZero    (bZero),
    .divDone  (divDone),
    .strb     (strb),
    .busy     (busy),
    .done     (done)
  );

  baudcalc_dpath #(
    .CLK_W   (CLK_W),
    .BAUD_W  (BAUD_W),
    .INC_W   (INC_W),
    .LIM_W   (LIM_W),
    .OVS_LOG2(OVS_LOG2)
  ) u_dpath (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .clkFreq  (clkFreq),
    .baudRate (baudRate),
    .inputsBad(inputsBad),
    .bZero    (bZero),
    .divDone  (divDone),
    .incWord  (incWord),
    .limitWord(limitWord),
    .overflow (overflow)
  );
endmodule

// File: rtl/baud_word_calc_chk.sv
module baud_word_calc_chk #(
  parameter int INC_W = 12,
  parameter int LIM_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             start,
  input logic             busy,
  input logic             done,
  input logic             overflow,
  input logic [INC_W-1:0] incWord,
  input logic [LIM_W-1:0] limitWord
);
  // R7
  done_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> busy);

  // R7
  done_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R7
  busy_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !busy);

  // R7
  start_accept_chk: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy) |=> busy);

  // R9
  out_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    !done |-> ($stable(incWord) && $stable(limitWord) && $stable(overflow)));

  // R5
  ovf_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    overflow |-> (incWord == '0 && limitWord == '0));
endmodule

bind baud_word_calc baud_word_calc_chk u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .start    (start),
  .busy     (busy),
  .done     (done),
  .overflow (overflow),
  .incWord  (incWord),
  .limitWord(limitWord)
);

// File: tb/baud_word_calc_bench.sv
module baud_word_calc_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [31:0] clkFreq = '0;
  logic [19:0] baudRate = '0;
  logic        busy, done, overflow;
  logic [11:0] incWord;
  logic [15:0] limitWord;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  baud_word_calc u_baud_word_calc (
    .clk(clk), .rstN(rstN), .start(start), .clkFreq(clkFreq),
    .baudRate(baudRate), .busy(busy), .done(done), .overflow(overflow),
    .incWord(incWord), .limitWord(limitWord)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic void model(input logic [63:0] c, input logic [63:0] b,
                                output logic [63:0] inc, output logic [63:0] lim,
                                output bit ovf, output bit badIn);
    logic [63:0] tick, x, y, t;
    tick  = b * 16;
    badIn = (c == 0) || (b == 0) || (tick > c);
    inc = 0; lim = 0; ovf = badIn;
    if (!badIn) begin
      x = c; y = tick;
      while (y != 0) begin t = x % y; x = y; y = t; end
      inc = tick / x;
      lim = c / x - inc;
      ovf = (inc > 4095) || (lim > 65535);
      if (ovf) begin inc = 0; lim = 0; end
    end
  endfunction

  task automatic runCase(input logic [63:0] c, input logic [63:0] b, input bit interfere);
    logic [63:0] eInc, eLim;
    bit eOvf, eBad;
    logic [11:0] pInc;
    logic [15:0] pLim;
    bit pOvf;
    int waitCnt;
    string rq;
    model(c, b, eInc, eLim, eOvf, eBad);
    pInc = incWord; pLim = limitWord; pOvf = overflow;
    @(negedge clk);
    clkFreq = c[31:0]; baudRate = b[19:0]; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, "R7", "busy after start", 64'(busy), 1);
    if (!done) begin
      // R9: previous result still visible during the run
      chk(incWord == pInc && limitWord == pLim && overflow == pOvf, "R9",
          "outputs held during run", 64'(incWord), 64'(pInc));
    end
    if (interfere) begin
      repeat (3) @(negedge clk);
      clkFreq = 32'd1000; baudRate = 20'd1; start = 1'b1;   // R8
      @(negedge clk);
      start = 1'b0;
    end
    waitCnt = 0;
    while (!done && waitCnt < 20000) begin
      @(negedge clk);
      waitCnt++;
    end
    if (!done) begin
      chk(1'b0, "R7", "done timeout", 0, 1);
      return;
    end
    rq = eBad ? "R6" : (eOvf ? "R5" : (interfere ? "R8" : "R2"));
    chk(incWord == eInc[11:0], rq, "incWord", 64'(incWord), eInc);
    rq = eBad ? "R6" : (eOvf ? "R5" : (interfere ? "R8" : "R3"));
    chk(limitWord == eLim[15:0], rq, "limitWord", 64'(limitWord), eLim);
    chk(overflow == eOvf, eBad ? "R6" : "R5", "overflow", 64'(overflow), 64'(eOvf));
    @(negedge clk);
    chk(!busy && !done, "R7", "idle after done", 64'({busy, done}), 0);
  endtask

  function automatic logic [63:0] clkOf(input int i);
    case (i)
      0: return 64'd1843200;
      1: return 64'd50000000;
      2: return 64'd12000000;
      3: return 64'd65536;
      4: return 64'd100000;
      default: return 64'd32768;
    endcase
  endfunction

  function automatic logic [63:0] baudOf(input int i);
    case (i)
      0: return 64'd300;
      1: return 64'd1200;
      2: return 64'd9600;
      3: return 64'd19200;
      4: return 64'd115200;
      5: return 64'd7;
      6: return 64'd1;
      default: return 64'd4095;
    endcase
  endfunction

  initial begin : watchdog
    #(CLK_PERIOD * 190000);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : main
    logic [11:0] hInc;
    logic [15:0] hLim;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!busy && !done && !overflow && incWord == 0 && limitWord == 0, "R1",
        "reset state", 64'({busy, done, overflow}), 0);
    rstN = 1'b1;
    @(negedge clk);
    chk(!busy && incWord == 0 && limitWord == 0, "R1", "after release", 64'(busy), 0);

    // R4 reference point
    runCase(64'd50000000, 64'd9600, 0);
    chk(incWord == 12'h030, "R4", "inc for 50M/9600", 64'(incWord), 64'h30);
    chk(limitWord == 16'h3CD9, "R4", "limit for 50M/9600", 64'(limitWord), 64'h3CD9);

    // R10 hold while idle
    hInc = incWord; hLim = limitWord;
    repeat (25) @(negedge clk);
    chk(incWord == hInc && limitWord == hLim, "R10", "hold while idle", 64'(limitWord), 64'(hLim));

    // R2/R3 sweep
    for (int ci = 0; ci < 6; ci++)
      for (int bi = 0; bi < 8; bi++)
        runCase(clkOf(ci), baudOf(bi), 0);

    // R5 boundaries
    runCase(64'd65536, 64'd4095, 0);    // inc exactly 4095
    runCase(64'd65552, 64'd4096, 0);    // inc 4096 -> overflow
    runCase(64'd1048576, 64'd1, 0);     // limit exactly 65535
    runCase(64'd1048592, 64'd1, 0);     // limit 65536 -> overflow

    // R6 invalid inputs and equality edge
    runCase(64'd0, 64'd9600, 0);
    runCase(64'd1000000, 64'd0, 0);
    runCase(64'd100, 64'd10, 0);        // tick 160 > 100
    runCase(64'd160, 64'd10, 0);        // tick equals clock: inc 1, limit 0
    chk(overflow == 0 && incWord == 1 && limitWord == 0, "R6", "tick equal clock valid",
        64'(incWord), 1);

    // R8 start and input change during a run
    runCase(64'd50000000, 64'd9600, 1);

    // R10 hold after an overflow result, then a fresh valid run
    runCase(64'd0, 64'd1, 0);
    repeat (10) @(negedge clk);
    chk(overflow == 1 && incWord == 0, "R10", "overflow result held", 64'(overflow), 1);
    runCase(64'd3686400, 64'd115200, 0);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule